// File: doc/BRIEF.md
# Memory protection region permission checker

This block judges every bus access against a small table of protection regions and answers, one clock later, whether the access is granted or must end with an access error. Each region holds an inclusive address window, a 32-bit access-control word, a process-identifier value and a mask. An access presents its master number (0 to 7), its privilege level, its kind (read, write or instruction fetch), its address and the current process identifier.

Masters 4 to 7 carry only a read-enable and a write-enable per region. Masters 0 to 3 carry a three-bit user-level permission field, a two-bit privileged-level code and a flag that adds a process-identifier comparison to the region's hit test. Where regions overlap, an access is granted when any region that hits it grants it. A region that hits but denies therefore does not block an access that another region allows. An access that no region hits is refused.

Descriptors are loaded through a simple synchronous register port. The access-control word can be written and read at two register offsets that share one store.

Top module: `mpu_region_checker`

## Requirements
- R1: A region hits an access on address only when start <= address <= end, both bounds inclusive and compared unsigned; register offset 0 holds the start and offset 1 the end.
- R2: For masters 4 to 7 only the read-enable and write-enable bits of the access-control word apply; a read needs read-enable, a write needs write-enable, an instruction fetch is judged by read-enable, and such masters have no process-identifier term.
- R3: For masters 0 to 3 at privileged level, the two-bit code 00 allows read, write and fetch, 01 allows read and fetch only, and 10 allows read and write only.
- R4: For masters 0 to 3 at privileged level, the code 11 makes the access follow that master's user-level {read, write, fetch} bits.
- R5: For masters 0 to 3 at user level, each of the three user bits independently allows read, write or fetch; the privileged code has no effect.
- R6: When a master 0 to 3 has its identifier flag set in a region, that region hits only if ((pid ^ region_pid) & ~mask) == 0, a set mask bit being a don't-care; with the flag clear the identifier has no effect.
- R7: An access is granted when at least one hitting region allows it; it is refused when no region hits, or when every hitting region denies it.
- R8: The access-control word is numbered from its most significant bit as bit 0: bits 0 to 7 hold read-enable then write-enable for masters 7, 6, 5, 4; from bit 8 each of masters 3, 2, 1, 0 takes six bits in that order: identifier flag, two-bit privileged code, then user read, write, fetch bits.
- R9: Register offsets 2 and 4 of a region both reach its access-control word: a write through either updates the one store and a read through either returns it; offset 3 holds the region identifier in bits 31:16 and the mask in bits 15:0; offsets 5 to 7 read as zero and ignore writes.
- R10: The outcome is registered: the cycle after acc_valid is sampled high, rsp_valid is high with exactly one of rsp_grant and rsp_error; after a cycle with acc_valid low all three are low.
- R11: After reset the response outputs are low and every descriptor word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address: region index above a 3-bit word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_master | input | 3 | Master number of the access |
| acc_super | input | 1 | 1 for privileged level, 0 for user level |
| acc_kind | input | 2 | 00 read, 01 write, 10 instruction fetch, 11 never allowed |
| acc_addr | input | ADDR_W | Access address |
| acc_pid | input | PID_W | Process identifier of the access |
| rsp_valid | output | 1 | Outcome present for the access of the previous cycle |
| rsp_grant | output | 1 | Access allowed |
| rsp_error | output | 1 | Access ends with an access error |

## Verification
The bench builds the checker with four regions, 32-bit addresses and an 8-bit identifier, which is enough for two overlapping windows, a one-address window and an identifier comparison with half its bits masked. Four regions let the same access hit a denying and a granting region at once. They also leave one region to be loaded solely through the alias offset. With an 8-bit identifier, both a match and a mismatch of the unmasked upper nibble are reachable under one mask.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  localparam int CTRL_W     = 32;
  localparam int PID_MAX_W  = 16;

  localparam logic [2:0] WORD_START = 3'd0;
  localparam logic [2:0] WORD_END   = 3'd1;
  localparam logic [2:0] WORD_CTRL  = 3'd2;
  localparam logic [2:0] WORD_PID   = 3'd3;
  localparam logic [2:0] WORD_CTRLA = 3'd4;

  // Effective {read, write, fetch} rights of one master in one region.
  // LSB-based view: masters 0..3 own six-bit slices from bit 0 upward
  // ({flag, code[1:0], r, w, x} high to low), masters 4..7 own two-bit
  // slices from bit 24 upward ({re, we} high to low).
  function automatic logic [2:0] master_rwx(input logic [CTRL_W-1:0] ctrl,
                                            input logic [2:0] mst,
                                            input logic super_lvl);
    logic [2:0] um;
    logic [1:0] sm;
    logic       re;
    logic       we;
    int         base;
    logic [2:0] res;
    if (mst[2]) begin
      base = 24 + 2 * int'(mst[1:0]);
      we   = ctrl[base];
      re   = ctrl[base+1];
      res  = {re, we, re};
    end else begin
      base = 6 * int'(mst[1:0]);
      um   = ctrl[base +: 3];
      sm   = ctrl[base+3 +: 2];
      if (!super_lvl) begin
        res = um;
      end else begin
        case (sm)
          2'b00:   res = 3'b111;
          2'b01:   res = 3'b101;
          2'b10:   res = 3'b110;
          default: res = um;
        endcase
      end
    end
    return res;
  endfunction

  function automatic logic pid_flag(input logic [CTRL_W-1:0] ctrl,
                                    input logic [2:0] mst);
    logic f;
    if (mst[2]) f = 1'b0;
    else        f = ctrl[6 * int'(mst[1:0]) + 5];
    return f;
  endfunction

  function automatic logic pid_match(input logic [PID_MAX_W-1:0] pid,
                                     input logic [PID_MAX_W-1:0] rpid,
                                     input logic [PID_MAX_W-1:0] mask);
    return ((pid ^ rpid) & ~mask) == '0;
  endfunction

  function automatic logic kind_allowed(input logic [2:0] rwx,
                                        input logic [1:0] kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = rwx[2];
      ACC_WRITE: ok = rwx[1];
      ACC_EXEC:  ok = rwx[0];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mpu_region_store.sv
module mpu_region_store
  import mpu_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int PID_W       = 8,
  parameter int RIDX_W      = 2,
  parameter int CFG_AW      = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [CFG_AW-1:0]                     cfg_addr,
  input  logic [31:0]                           cfg_wdata,
  output logic [31:0]                           cfg_rdata,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    start_q,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    end_q,
  output logic [NUM_REGIONS-1:0][CTRL_W-1:0]    ctrl_q,
  output logic [NUM_REGIONS-1:0][PID_W-1:0]     rpid_q,
  output logic [NUM_REGIONS-1:0][PID_W-1:0]     mask_q,
  output logic                                  ctrl_wr_strobe,
  output logic [RIDX_W-1:0]                     ctrl_wr_idx
);

  logic [2:0]        word_sel;
  logic [RIDX_W-1:0] ridx;
  logic              ridx_ok;

  assign word_sel = cfg_addr[2:0];
  assign ridx     = cfg_addr[CFG_AW-1:3];
  assign ridx_ok  = (int'(ridx) < NUM_REGIONS);

  // Both control-word offsets land on the same store.
  assign ctrl_wr_strobe = cfg_we && ridx_ok &&
                          (word_sel == WORD_CTRL || word_sel == WORD_CTRLA);
  assign ctrl_wr_idx    = ridx;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    logic sel;
    assign sel = cfg_we && ridx_ok && (int'(ridx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[g] <= '0;
        end_q[g]   <= '0;
        ctrl_q[g]  <= '0;
        rpid_q[g]  <= '0;
        mask_q[g]  <= '0;
      end else if (sel) begin
        case (word_sel)
          WORD_START: start_q[g] <= cfg_wdata[ADDR_W-1:0];
          WORD_END:   end_q[g]   <= cfg_wdata[ADDR_W-1:0];
          WORD_CTRL,
          WORD_CTRLA: ctrl_q[g]  <= cfg_wdata;
          WORD_PID: begin
            rpid_q[g] <= cfg_wdata[16 +: PID_W];
            mask_q[g] <= cfg_wdata[0 +: PID_W];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (ridx_ok) begin
      case (word_sel)
        WORD_START: cfg_rdata = 32'(start_q[ridx]);
        WORD_END:   cfg_rdata = 32'(end_q[ridx]);
        WORD_CTRL,
        WORD_CTRLA: cfg_rdata = ctrl_q[ridx];
        WORD_PID:   cfg_rdata = (32'(rpid_q[ridx]) << 16) | 32'(mask_q[ridx]);
        default:    cfg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mpu_region_eval.sv
module mpu_region_eval
  import mpu_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 8
) (
  input  logic [ADDR_W-1:0] r_start,
  input  logic [ADDR_W-1:0] r_end,
  input  logic [CTRL_W-1:0] r_ctrl,
  input  logic [PID_W-1:0]  r_pid,
  input  logic [PID_W-1:0]  r_mask,
  input  logic [2:0]        acc_master,
  input  logic              acc_super,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PID_W-1:0]  acc_pid,
  output logic              hit,
  output logic              allow
);

  logic       in_window;
  logic       pid_ok;
  logic [2:0] rwx;

  assign in_window = (acc_addr >= r_start) && (acc_addr <= r_end);
  assign pid_ok    = !pid_flag(r_ctrl, acc_master) ||
                     pid_match(PID_MAX_W'(acc_pid), PID_MAX_W'(r_pid),
                               PID_MAX_W'(r_mask));
  assign rwx       = master_rwx(r_ctrl, acc_master, acc_super);
  assign hit       = in_window && pid_ok;
  assign allow     = hit && kind_allowed(rwx, acc_kind);

endmodule

// File: rtl/mpu_resp_stage.sv
module mpu_resp_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic any_allow,
  output logic rsp_valid,
  output logic rsp_grant,
  output logic rsp_error
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_error <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_grant <= acc_valid && any_allow;
      rsp_error <= acc_valid && !any_allow;
    end
  end

endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
  import mpu_chk_pkg::*;
#(
  parameter  int NUM_REGIONS = 4,
  parameter  int ADDR_W      = 32,
  parameter  int PID_W       = 8,
  localparam int RIDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int CFG_AW      = RIDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [2:0]        acc_master,
  input  logic              acc_super,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PID_W-1:0]  acc_pid,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_error
);

  logic [NUM_REGIONS-1:0][ADDR_W-1:0] start_q;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] end_q;
  logic [NUM_REGIONS-1:0][CTRL_W-1:0] ctrl_q;
  logic [NUM_REGIONS-1:0][PID_W-1:0]  rpid_q;
  logic [NUM_REGIONS-1:0][PID_W-1:0]  mask_q;

  // Named internal events for the bound checker.
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [NUM_REGIONS-1:0] allow_vec;
  logic                   any_allow;
  logic                   ctrl_wr_strobe;
  logic [RIDX_W-1:0]      ctrl_wr_idx;

  mpu_region_store #(
    .NUM_REGIONS(NUM_REGIONS),
    .ADDR_W     (ADDR_W),
    .PID_W      (PID_W),
    .RIDX_W     (RIDX_W),
    .CFG_AW     (CFG_AW)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .start_q       (start_q),
    .end_q         (end_q),
    .ctrl_q        (ctrl_q),
    .rpid_q        (rpid_q),
    .mask_q        (mask_q),
    .ctrl_wr_strobe(ctrl_wr_strobe),
    .ctrl_wr_idx   (ctrl_wr_idx)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_eval
    mpu_region_eval #(
      .ADDR_W(ADDR_W),
      .PID_W (PID_W)
    ) u_eval (
      .r_start   (start_q[g]),
      .r_end     (end_q[g]),
      .r_ctrl    (ctrl_q[g]),
      .r_pid     (rpid_q[g]),
      .r_mask    (mask_q[g]),
      .acc_master(acc_master),
      .acc_super (acc_super),
      .acc_kind  (acc_kind),
      .acc_addr  (acc_addr),
      .acc_pid   (acc_pid),
      .hit       (hit_vec[g]),
      .allow     (allow_vec[g])
    );
  end

  assign any_allow = |allow_vec;

  mpu_resp_stage u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .any_allow(any_allow),
    .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant),
    .rsp_error(rsp_error)
  );

endmodule

// File: rtl/mpu_region_checker_sva.sv
module mpu_region_checker_sva
  import mpu_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int RIDX_W      = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [31:0]                        cfg_wdata,
  input logic                               acc_valid,
  input logic                               rsp_valid,
  input logic                               rsp_grant,
  input logic                               rsp_error,
  input logic [NUM_REGIONS-1:0]             hit_vec,
  input logic [NUM_REGIONS-1:0]             allow_vec,
  input logic [NUM_REGIONS-1:0][CTRL_W-1:0] ctrl_q,
  input logic                               ctrl_wr_strobe,
  input logic [RIDX_W-1:0]                  ctrl_wr_idx
);

  // R10: one registered outcome per sampled access
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!rsp_valid && !rsp_grant && !rsp_error));
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_grant, rsp_error}) == 1));

  // R7: allow only from a hitting region; no hit refuses; any allow grants
  a_r7_allow_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_vec & ~hit_vec) == '0);
  a_r7_no_hit_error: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit_vec == '0) |=> rsp_error);
  a_r7_any_allow_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && allow_vec != '0) |=> rsp_grant);

  // R9: a write through either control offset lands in the one store
  a_r9_alias_same_store: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_strobe |=> (ctrl_q[$past(ctrl_wr_idx)] == $past(cfg_wdata)));

endmodule

bind mpu_region_checker mpu_region_checker_sva #(
  .NUM_REGIONS(NUM_REGIONS),
  .RIDX_W     (RIDX_W)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wdata     (cfg_wdata),
  .acc_valid     (acc_valid),
  .rsp_valid     (rsp_valid),
  .rsp_grant     (rsp_grant),
  .rsp_error     (rsp_error),
  .hit_vec       (hit_vec),
  .allow_vec     (allow_vec),
  .ctrl_q        (ctrl_q),
  .ctrl_wr_strobe(ctrl_wr_strobe),
  .ctrl_wr_idx   (ctrl_wr_idx)
);

// File: tb/test_mpu_region_checker.sv
module test_mpu_region_checker;

  localparam int NR     = 4;
  localparam int AW     = 32;
  localparam int PW     = 8;
  localparam int CAW    = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [31:0]    cfg_rdata;
  logic           acc_valid = 1'b0;
  logic [2:0]     acc_master = '0;
  logic           acc_super = 1'b0;
  logic [1:0]     acc_kind = '0;
  logic [AW-1:0]  acc_addr = '0;
  logic [PW-1:0]  acc_pid = '0;
  logic           rsp_valid;
  logic           rsp_grant;
  logic           rsp_error;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    grant;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  mpu_region_checker #(.NUM_REGIONS(NR), .ADDR_W(AW), .PID_W(PW)) i_mpu_region_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_master(acc_master), .acc_super(acc_super), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_pid(acc_pid), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_error(rsp_error)
  );

  // Access-control word built with bit n counted from the MSB (R8).
  function automatic logic [31:0] put_rw(input logic [31:0] c, input int m,
                                         input bit re, input bit we);
    int n = 2 * (7 - m);
    c[31 - n]       = re;
    c[31 - (n + 1)] = we;
    return c;
  endfunction

  function automatic logic [31:0] put_lo(input logic [31:0] c, input int m,
                                         input bit pe, input bit [1:0] sm,
                                         input bit [2:0] um);
    int n = 8 + 6 * (3 - m);
    c[31 - n]       = pe;
    c[31 - (n + 1)] = sm[1];
    c[31 - (n + 2)] = sm[0];
    c[31 - (n + 3)] = um[2];
    c[31 - (n + 4)] = um[1];
    c[31 - (n + 5)] = um[0];
    return c;
  endfunction

  function automatic void tally(input bit ok, input string req,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  task automatic cfg_write(input int region, input int word, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = CAW'(region * 8 + word);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic cfg_check(input int region, input int word, input logic [31:0] exp,
                           input string req);
    @(negedge clk);
    cfg_addr = CAW'(region * 8 + word);
    #1;
    tally(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  // Driver: present one access and queue its expected outcome.
  task automatic access(input int m, input bit sup, input logic [1:0] kind,
                        input logic [31:0] addr, input logic [7:0] pid,
                        input bit exp_grant, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid  = 1'b1;
    acc_master = 3'(m);
    acc_super  = sup;
    acc_kind   = kind;
    acc_addr   = addr;
    acc_pid    = pid;
    e.grant    = exp_grant;
    e.tag      = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
    end
  endtask

  // Monitor: compare each outcome one clock after its request.
  always @(posedge clk) begin
    #1;
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        tally(1'b0, "R10 unexpected response", 32'(rsp_grant), 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        tally(rsp_grant == e.grant && rsp_error == !e.grant, e.tag,
              {30'b0, rsp_grant, rsp_error}, {30'b0, e.grant, !e.grant});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, c1, c2, c3;

    repeat (3) @(negedge clk);
    // R11: reset state
    tally(!rsp_valid && !rsp_grant && !rsp_error, "R11 outputs after reset",
          {29'b0, rsp_valid, rsp_grant, rsp_error}, 32'h0);
    rst_n = 1'b1;
    cfg_check(0, 2, 32'h0, "R11 ctrl word after reset");
    cfg_check(2, 1, 32'h0, "R11 end word after reset");

    // Region 0: 0x1000..0x1FFF
    c0 = '0;
    c0 = put_rw(c0, 7, 1'b1, 1'b0);
    c0 = put_rw(c0, 4, 1'b0, 1'b1);
    c0 = put_lo(c0, 0, 1'b0, 2'b00, 3'b000);
    c0 = put_lo(c0, 1, 1'b0, 2'b01, 3'b000);
    c0 = put_lo(c0, 2, 1'b0, 2'b10, 3'b000);
    c0 = put_lo(c0, 3, 1'b0, 2'b11, 3'b101);
    cfg_write(0, 0, 32'h1000);
    cfg_write(0, 1, 32'h1FFF);
    cfg_write(0, 2, c0);

    // Region 1: 0x4000..0x4FFF, master 2 identifier-gated full rights
    c1 = put_lo(32'h0, 2, 1'b1, 2'b11, 3'b111);
    cfg_write(1, 0, 32'h4000);
    cfg_write(1, 1, 32'h4FFF);
    cfg_write(1, 2, c1);
    cfg_write(1, 3, 32'h005A_000F);

    // Region 2: 0x4000..0x40FF overlapping, master 2 read only, master 5 read
    c2 = put_lo(32'h0, 2, 1'b0, 2'b11, 3'b100);
    c2 = put_rw(c2, 5, 1'b1, 1'b0);
    cfg_write(2, 0, 32'h4000);
    cfg_write(2, 1, 32'h40FF);
    cfg_write(2, 2, c2);

    // Region 3: single address 0x8000, control loaded through the alias
    c3 = put_rw(32'h0, 6, 1'b0, 1'b1);
    cfg_write(3, 0, 32'h8000);
    cfg_write(3, 1, 32'h8000);
    cfg_write(3, 4, c3);
    cfg_check(3, 2, c3, "R9 alias write read at primary");
    cfg_check(3, 4, c3, "R9 alias read back");
    cfg_check(1, 4, c1, "R9 primary write read at alias");
    cfg_check(1, 3, 32'h005A_000F, "R9 identifier word");
    cfg_write(1, 5, 32'hFFFF_FFFF);
    cfg_check(1, 5, 32'h0, "R9 unused offset reads zero");
    cfg_check(1, 2, c1, "R9 unused offset write leaves ctrl");

    // R1 / R2: masters 4..7
    access(7, 1'b1, 2'b00, 32'h1000, 8'h00, 1'b1, "R1 R2 m7 read at start");
    access(7, 1'b1, 2'b01, 32'h1FFF, 8'h00, 1'b0, "R2 m7 write denied at end");
    access(7, 1'b0, 2'b00, 32'h1FFF, 8'h00, 1'b1, "R1 m7 read at end bound");
    access(7, 1'b0, 2'b00, 32'h2000, 8'h00, 1'b0, "R1 R7 m7 read past end");
    access(7, 1'b0, 2'b00, 32'h0FFF, 8'h00, 1'b0, "R1 R7 m7 read below start");
    access(7, 1'b0, 2'b10, 32'h1800, 8'h00, 1'b1, "R2 m7 fetch uses read-enable");
    access(4, 1'b0, 2'b01, 32'h1800, 8'h00, 1'b1, "R2 m4 write enabled");
    access(4, 1'b0, 2'b00, 32'h1800, 8'h00, 1'b0, "R2 m4 read denied");
    access(4, 1'b1, 2'b10, 32'h1800, 8'h00, 1'b0, "R2 m4 fetch denied");
    // R3: privileged codes
    access(0, 1'b1, 2'b01, 32'h1800, 8'h00, 1'b1, "R3 code 00 write");
    access(0, 1'b1, 2'b10, 32'h1800, 8'h00, 1'b1, "R3 code 00 fetch");
    access(1, 1'b1, 2'b01, 32'h1800, 8'h00, 1'b0, "R3 code 01 write denied");
    access(1, 1'b1, 2'b10, 32'h1800, 8'h00, 1'b1, "R3 code 01 fetch");
    access(1, 1'b1, 2'b00, 32'h1800, 8'h00, 1'b1, "R3 code 01 read");
    access(2, 1'b1, 2'b10, 32'h1800, 8'h00, 1'b0, "R3 code 10 fetch denied");
    access(2, 1'b1, 2'b01, 32'h1800, 8'h00, 1'b1, "R3 code 10 write");
    // R4: code 11 follows user bits r-x
    access(3, 1'b1, 2'b01, 32'h1800, 8'h00, 1'b0, "R4 code 11 write per user bits");
    access(3, 1'b1, 2'b10, 32'h1800, 8'h00, 1'b1, "R4 code 11 fetch per user bits");
    // R5: user level
    access(3, 1'b0, 2'b00, 32'h1800, 8'h00, 1'b1, "R5 user read");
    access(3, 1'b0, 2'b01, 32'h1800, 8'h00, 1'b0, "R5 user write denied");
    access(0, 1'b0, 2'b00, 32'h1800, 8'h00, 1'b0, "R5 user ignores code 00");
    access(0, 1'b1, 2'b11, 32'h1800, 8'h00, 1'b0, "R7 kind 11 never allowed");
    idle(1);
    // R10: idle cycle gives no response
    @(negedge clk);
    tally(!rsp_valid && !rsp_grant && !rsp_error, "R10 idle quiet",
          {29'b0, rsp_valid, rsp_grant, rsp_error}, 32'h0);

    // R6 / R7: identifier and overlap
    access(2, 1'b0, 2'b01, 32'h4800, 8'h53, 1'b1, "R6 pid match under mask");
    access(2, 1'b0, 2'b01, 32'h4800, 8'h63, 1'b0, "R6 pid mismatch no hit");
    access(2, 1'b0, 2'b01, 32'h4010, 8'h63, 1'b0, "R7 hit region denies write");
    access(2, 1'b0, 2'b00, 32'h4010, 8'h63, 1'b1, "R6 R7 flag clear ignores pid");
    access(2, 1'b0, 2'b01, 32'h4010, 8'h5F, 1'b1, "R7 one granting region wins");
    access(5, 1'b0, 2'b00, 32'h4020, 8'hFF, 1'b1, "R2 R6 m5 read no pid term");
    access(5, 1'b0, 2'b01, 32'h4020, 8'h00, 1'b0, "R2 m5 write denied");
    // R9 / R1: region loaded through alias, single address
    access(6, 1'b0, 2'b01, 32'h8000, 8'h00, 1'b1, "R9 R1 alias ctrl grants write");
    access(6, 1'b0, 2'b01, 32'h8001, 8'h00, 1'b0, "R1 one past single address");
    access(6, 1'b0, 2'b00, 32'h8000, 8'h00, 1'b0, "R8 m6 read bit clear");
    idle(3);
    tally(exp_q.size() == 0, "R10 all responses seen", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule